// File: doc/BRIEF.md
# Branch Target and Call Push Unit

This block works out the next program counter for one instruction. The instruction is one of these: a plain one-step advance, a jump or call within the current 2 KB page, a jump or call to any 16-bit address, a short jump by a signed 8-bit displacement, or a compare-and-branch on inequality. A strobe launches each computation. The result is registered and marked by a one-cycle `done` pulse.

A call also saves a 16-bit return address on an 8-bit-pointer stack that grows upward. The block issues two byte writes on consecutive cycles, low byte first. It pre-increments the pointer before each write. The new pointer is returned to the caller, and the stack memory itself lies outside the block.

The compare form yields an unsigned less-than carry and a write enable for it. Neither compared operand is changed. The block does not fetch instructions and does not handle returns.

Top module: `pc_target_unit`

## Requirements
- R1: After reset, `pc_out`, `sp_out`, `stk_addr` and `stk_data` are 0, and `done`, `stk_we`, `carry_out` and `cmp_we` are low.
- R2: An opcode not listed in R3 to R7 is a one-byte sequential instruction. One cycle after an accepted start, `pc_out` is `pc_in`+1 and `done` pulses.
- R3: An opcode whose low five bits are 00001 is a page jump. The target is bits 15:11 of `pc_in`+2, followed by opcode bits 7:5, followed by `op1`. The result appears one cycle after start.
- R4: An opcode whose low five bits are 10001 is a page call. It has the same target as R3, and its return address is `pc_in`+2.
- R5: Opcode 0x02 is a long jump to {`op1`,`op2`}, with `op1` as the high byte. Opcode 0x12 is a long call to the same target, with return address `pc_in`+3.
- R6: Opcode 0x80 is a short jump to `pc_in`+2 plus `op1` sign-extended, giving a reach of -128 to +127.
- R7: Opcode 0xB5 is compare-and-branch. The target is `pc_in`+3 when `cmp_a` equals `cmp_b`. Otherwise the target is `pc_in`+3 plus `op2` sign-extended. `carry_out` is loaded with (`cmp_a` < `cmp_b`, unsigned), and `cmp_we` pulses together with `done`.
- R8: A call asserts `stk_we` on the two cycles after start. The first write goes to address `sp_in`+1 with the return address low byte. The second goes to `sp_in`+2 with the high byte. `sp_out` equals the address of each write. `pc_out` and `done` update with the second write.
- R9: An instruction that is not a call writes nothing to the stack and sets `sp_out` to `sp_in`. An instruction that is not a compare leaves `carry_out` unchanged.
- R10: PC arithmetic wraps modulo 2^16, and stack pointer increments wrap modulo 2^8.
- R11: A start that arrives on the cycle of a call's second write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one target computation |
| pc_in | input | 16 | Address of the instruction's first byte |
| opcode | input | 8 | Instruction opcode |
| op1 | input | 8 | Second instruction byte |
| op2 | input | 8 | Third instruction byte |
| cmp_a | input | 8 | Compare destination operand |
| cmp_b | input | 8 | Compare source operand |
| sp_in | input | 8 | Current stack pointer |
| pc_out | output | 16 | New program counter |
| done | output | 1 | One-cycle pulse when `pc_out` is updated |
| carry_out | output | 1 | Compare carry result |
| cmp_we | output | 1 | Carry write enable for a compare |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | 8 | Stack write address |
| stk_data | output | 8 | Stack write data |
| sp_out | output | 8 | New stack pointer |

## Verification
Every instruction that is not a call has its `pc_out`, `done`, `sp_out`, carry and `cmp_we` results due one clock after the start edge. A call's first stack write is due one clock after start. The second write, together with `pc_out` and `done`, is due two clocks after start. The bench model applies each start at the same clock edge as the design does and holds these latencies. Every output is compared two nanoseconds after each rising edge, so a result sampled one cycle early or late shows up as a mismatch.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    K_SEQ, K_PJMP, K_PCALL, K_LJMP, K_LCALL, K_SJMP, K_CMPJ
  } pc_kind_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opcode,
  output pc_kind_e          kind
);
  always_comb begin
    kind = K_SEQ;
    if (opcode[4:0] == 5'b00001)      kind = K_PJMP;
    else if (opcode[4:0] == 5'b10001) kind = K_PCALL;
    else begin
      case (opcode)
        8'h02:   kind = K_LJMP;
        8'h12:   kind = K_LCALL;
        8'h80:   kind = K_SJMP;
        8'hB5:   kind = K_CMPJ;
        default: kind = K_SEQ;
      endcase
    end
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic [PC_W-1:0]   pc,
  input  pc_kind_e          kind,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  input  logic [BYTE_W-1:0] cmp_a,
  input  logic [BYTE_W-1:0] cmp_b,
  output logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   ret_addr,
  output logic              cmp_lt
);
  localparam int SEL_W = PAGE_W - BYTE_W;
  localparam int EXT_W = PC_W - BYTE_W;
  localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP3 = PC_W'(3);

  logic [PC_W-1:0] pc_p1, pc_p2, pc_p3, page_tgt;

  function automatic logic [PC_W-1:0] sext(input logic [BYTE_W-1:0] d);
    return {{EXT_W{d[BYTE_W-1]}}, d};
  endfunction

  assign pc_p1    = pc + STEP1;
  assign pc_p2    = pc + STEP2;
  assign pc_p3    = pc + STEP3;
  assign page_tgt = {pc_p2[PC_W-1:PAGE_W], opcode[BYTE_W-1 -: SEL_W], op1};
  assign cmp_lt   = (cmp_a < cmp_b);

  always_comb begin
    ret_addr = pc_p2;
    case (kind)
      K_PJMP, K_PCALL: target = page_tgt;
      K_LJMP:          target = {op1, op2};
      K_LCALL: begin
        target   = {op1, op2};
        ret_addr = pc_p3;
      end
      K_SJMP:          target = pc_p2 + sext(op1);
      K_CMPJ:          target = (cmp_a != cmp_b) ? pc_p3 + sext(op2) : pc_p3;
      default:         target = pc_p1;
    endcase
  end
endmodule

// File: rtl/pcu_call_seq.sv
module pcu_call_seq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_call,
  output logic accept,
  output logic first_push,
  output logic second_push,
  output logic busy
);
  typedef enum logic {S_IDLE, S_HIGH} seq_e;
  seq_e state;

  assign busy        = (state == S_HIGH);
  assign accept      = start && !busy;
  assign first_push  = accept && is_call;
  assign second_push = busy;

  always_ff @(posedge clk) begin
    if (rst)             state <= S_IDLE;
    else if (first_push) state <= S_HIGH;
    else                 state <= S_IDLE;
  end
endmodule

// File: rtl/pc_target_unit.sv
module pc_target_unit
  import pcu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int SP_W   = 8,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] op1,
  input  logic [BYTE_W-1:0] op2,
  input  logic [BYTE_W-1:0] cmp_a,
  input  logic [BYTE_W-1:0] cmp_b,
  input  logic [SP_W-1:0]   sp_in,
  output logic [PC_W-1:0]   pc_out,
  output logic              done,
  output logic              carry_out,
  output logic              cmp_we,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_data,
  output logic [SP_W-1:0]   sp_out
);
  localparam int HI_W = PC_W - BYTE_W;
  localparam logic [SP_W-1:0] SP_STEP = SP_W'(1);

  pc_kind_e        kind;
  logic [PC_W-1:0] target, ret_addr;
  logic            cmp_lt, is_call, accept, first_push, second_push, busy;
  logic [HI_W-1:0] hold_hi;
  logic [PC_W-1:0] hold_tgt;

  pcu_decode #(.BYTE_W(BYTE_W)) i_dec (.opcode(opcode), .kind(kind));

  pcu_target #(.PC_W(PC_W), .BYTE_W(BYTE_W), .PAGE_W(PAGE_W)) i_tgt (
    .pc(pc_in), .kind(kind), .opcode(opcode), .op1(op1), .op2(op2),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .target(target), .ret_addr(ret_addr),
    .cmp_lt(cmp_lt)
  );

  assign is_call = (kind == K_PCALL) || (kind == K_LCALL);

  pcu_call_seq i_seq (
    .clk(clk), .rst(rst), .start(start), .is_call(is_call),
    .accept(accept), .first_push(first_push), .second_push(second_push),
    .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out    <= '0;
      done      <= 1'b0;
      carry_out <= 1'b0;
      cmp_we    <= 1'b0;
      stk_we    <= 1'b0;
      stk_addr  <= '0;
      stk_data  <= '0;
      sp_out    <= '0;
      hold_hi   <= '0;
      hold_tgt  <= '0;
    end else begin
      done   <= 1'b0;
      cmp_we <= 1'b0;
      stk_we <= 1'b0;
      if (second_push) begin
        stk_we   <= 1'b1;
        stk_addr <= stk_addr + SP_STEP;
        sp_out   <= stk_addr + SP_STEP;
        stk_data <= hold_hi;
        pc_out   <= hold_tgt;
        done     <= 1'b1;
      end else if (first_push) begin
        stk_we   <= 1'b1;
        stk_addr <= sp_in + SP_STEP;
        sp_out   <= sp_in + SP_STEP;
        stk_data <= ret_addr[BYTE_W-1:0];
        hold_hi  <= ret_addr[PC_W-1:BYTE_W];
        hold_tgt <= target;
      end else if (accept) begin
        pc_out <= target;
        done   <= 1'b1;
        sp_out <= sp_in;
        if (kind == K_CMPJ) begin
          carry_out <= cmp_lt;
          cmp_we    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int PC_W   = 16,
  parameter int SP_W   = 8,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [BYTE_W-1:0] opcode,
  input logic [BYTE_W-1:0] op1,
  input logic [BYTE_W-1:0] op2,
  input logic              busy,
  input logic              done,
  input logic              stk_we,
  input logic [SP_W-1:0]   stk_addr,
  input logic [SP_W-1:0]   sp_out,
  input logic              cmp_we,
  input logic [PC_W-1:0]   pc_out
);
  // R8: a first push is always followed by a second push that completes the call
  p_second_push_r8: assert property (@(posedge clk) disable iff (rst)
    (stk_we && !done) |=> (stk_we && done));

  // R8 / R10: consecutive pushes step the address by one, modulo 2^8
  p_push_step_r8: assert property (@(posedge clk) disable iff (rst)
    (stk_we && done) |-> (stk_addr == $past(stk_addr) + SP_W'(1)));

  // R8: the returned pointer tracks each write address
  p_sp_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> (sp_out == stk_addr));

  // R7: carry write only together with completion
  p_cmp_we_done_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_we |-> (done && !stk_we));

  // R5: long jump lands on the operand pair one cycle later
  p_ljmp_target_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && opcode == 8'h02) |=> (done && pc_out == {$past(op1), $past(op2)}));

  // R11: a start during the second push does not launch anything
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (!stk_we || done));
endmodule

bind pc_target_unit pcu_checker #(.PC_W(PC_W), .SP_W(SP_W), .BYTE_W(BYTE_W)) i_pcu_checker (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .op1(op1), .op2(op2),
  .busy(busy), .done(done), .stk_we(stk_we), .stk_addr(stk_addr),
  .sp_out(sp_out), .cmp_we(cmp_we), .pc_out(pc_out)
);

// File: tb/test_pc_target_unit.sv
module test_pc_target_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  opcode = '0, op1 = '0, op2 = '0, cmp_a = '0, cmp_b = '0, sp_in = '0;
  logic [15:0] pc_out;
  logic        done, carry_out, cmp_we, stk_we;
  logic [7:0]  stk_addr, stk_data, sp_out;

  int checks = 0, fails = 0, cycles = 0;

  // model state
  int    e_pc = 0, e_addr = 0, e_data = 0, e_sp = 0;
  bit    e_done = 0, e_we = 0, e_c = 0, e_cwe = 0;
  bit    m_busy = 0;
  int    m_hi = 0, m_tgt = 0;
  string m_req = "R1";

  always #4 clk = ~clk;

  pc_target_unit i_pc_target_unit (
    .clk(clk), .rst(rst), .start(start), .pc_in(pc_in), .opcode(opcode),
    .op1(op1), .op2(op2), .cmp_a(cmp_a), .cmp_b(cmp_b), .sp_in(sp_in),
    .pc_out(pc_out), .done(done), .carry_out(carry_out), .cmp_we(cmp_we),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data), .sp_out(sp_out)
  );

  function automatic int sx(int b);
    return (b >= 128) ? b - 256 : b;
  endfunction

  // Reference: next PC, return address, call flag and requirement tag from the R2..R7 rules
  task automatic ref_op(input int pc, op, a1, a2, ca, cb,
                        output int tgt, output int ret, output bit call, output string req);
    int nx2, nx3;
    nx2 = (pc + 2) % 65536;
    nx3 = (pc + 3) % 65536;
    call = 0; ret = 0;
    if ((op % 32) == 1) begin
      tgt = (nx2 / 2048) * 2048 + (op / 32) * 256 + a1; req = "R3";
    end else if ((op % 32) == 17) begin
      tgt = (nx2 / 2048) * 2048 + (op / 32) * 256 + a1; ret = nx2; call = 1; req = "R4";
    end else if (op == 2) begin
      tgt = a1 * 256 + a2; req = "R5";
    end else if (op == 18) begin
      tgt = a1 * 256 + a2; ret = nx3; call = 1; req = "R5";
    end else if (op == 128) begin
      tgt = (nx2 + sx(a1) + 65536) % 65536; req = "R6";
    end else if (op == 181) begin
      tgt = (ca != cb) ? (nx3 + sx(a2) + 65536) % 65536 : nx3; req = "R7";
    end else begin
      tgt = (pc + 1) % 65536; req = "R2";
    end
  endtask

  always @(posedge clk) begin
    int tgt, ret;
    bit call;
    string req;
    if (rst) begin
      e_pc <= 0; e_done <= 0; e_we <= 0; e_addr <= 0; e_data <= 0; e_sp <= 0;
      e_c <= 0; e_cwe <= 0; m_busy <= 0; m_req <= "R1";
    end else begin
      e_done <= 0; e_we <= 0; e_cwe <= 0; m_busy <= 0;
      if (m_busy) begin
        e_we <= 1; e_addr <= (e_addr + 1) % 256; e_sp <= (e_addr + 1) % 256;
        e_data <= m_hi; e_pc <= m_tgt; e_done <= 1; m_req <= "R8";
      end else if (start) begin
        ref_op(pc_in, opcode, op1, op2, cmp_a, cmp_b, tgt, ret, call, req);
        m_req <= req;
        if (call) begin
          e_we <= 1; e_addr <= (sp_in + 1) % 256; e_sp <= (sp_in + 1) % 256;
          e_data <= ret % 256; m_hi <= ret / 256; m_tgt <= tgt; m_busy <= 1;
        end else begin
          e_pc <= tgt; e_done <= 1; e_sp <= sp_in;
          if (opcode == 8'hB5) begin e_c <= (cmp_a < cmp_b); e_cwe <= 1; end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    chk(m_req, "pc_out", pc_out, e_pc);
    chk(m_req, "done", done, e_done);
    chk("R8", "stk_we", stk_we, e_we);
    if (e_we) begin
      chk("R8", "stk_addr", stk_addr, e_addr);
      chk("R8", "stk_data", stk_data, e_data);
    end
    chk("R9", "sp_out", sp_out, e_sp);
    chk("R7", "carry_out", carry_out, e_c);
    chk("R7", "cmp_we", cmp_we, e_cwe);
    cycles++;
    if (cycles > 50000) begin
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic issue(input int pc, op, a1, a2, sp, ca, cb);
    @(negedge clk);
    pc_in = 16'(pc); opcode = 8'(op); op1 = 8'(a1); op2 = 8'(a2);
    sp_in = 8'(sp); cmp_a = 8'(ca); cmp_b = 8'(cb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values are compared by the per-cycle monitor during these cycles
    rst = 1'b0;
    // R4 / R8: page call from 0x0123 to 0x0345 with pointer 0x07
    issue(16'h0123, 8'h71, 8'h45, 0, 8'h07, 0, 0);
    chk("R8", "final sp", sp_out, 8'h09);
    chk("R4", "final pc", pc_out, 16'h0345);
    // R3: page jump whose next address crosses into page 1
    issue(16'h07FE, 8'hA1, 8'h10, 0, 8'h20, 0, 0);
    chk("R3", "page cross", pc_out, 16'h0D10);
    // R5 long jump and long call with pointer wrap (R10)
    issue(16'h1234, 8'h02, 8'hBE, 8'hEF, 8'h30, 0, 0);
    issue(16'hFFFE, 8'h12, 8'h40, 8'h00, 8'hFF, 0, 0);
    chk("R10", "sp wrap", sp_out, 8'h01);
    // R6: backward short jump wrapping below zero (R10)
    issue(16'h0001, 8'h80, 8'h80, 0, 8'h11, 0, 0);
    chk("R10", "pc wrap", pc_out, 16'hFF83);
    issue(16'h4000, 8'h80, 8'h7F, 0, 8'h11, 0, 0);
    // R7: equal, less, greater compares
    issue(16'h2000, 8'hB5, 8'h90, 8'hF0, 8'h11, 8'h34, 8'h34);
    issue(16'h2000, 8'hB5, 8'h90, 8'hF0, 8'h11, 8'h12, 8'h56);
    chk("R7", "carry less", carry_out, 1);
    issue(16'h2000, 8'hB5, 8'h90, 8'h05, 8'h11, 8'h80, 8'h7F);
    // R9: non-compare keeps carry, R2 sequential wrap
    issue(16'h2000, 8'hB5, 8'h90, 8'h05, 8'h11, 8'h01, 8'h02);
    issue(16'hFFFF, 8'h00, 0, 0, 8'h22, 0, 0);
    chk("R9", "carry held", carry_out, 1);
    // R11: start held through a call; second cycle start is ignored
    @(negedge clk);
    pc_in = 16'h0500; opcode = 8'h12; op1 = 8'h12; op2 = 8'h34; sp_in = 8'h40; start = 1'b1;
    @(negedge clk);
    opcode = 8'h00; pc_in = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    chk("R11", "ignored start", pc_out, 16'h1234);
    @(negedge clk);
    // mixed sequence
    for (int i = 0; i < 300; i++) begin
      int ops[8] = '{8'h01, 8'h31, 8'h02, 8'h12, 8'h80, 8'hB5, 8'h04, 8'hF1};
      issue($urandom % 65536, ops[$urandom % 8], $urandom % 256, $urandom % 256,
            $urandom % 256, $urandom % 4, $urandom % 4);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule